// File: doc/BRIEF.md
# Triggered DAC Sample Sequencer

This block paces 12-bit samples from a bus-side writer into a DAC output latch. In queued mode, accepted samples are stored in a 16-entry queue. Each trigger from the selected source moves the oldest stored sample into the output latch.

The trigger source can be a hardware pulse input or a software strobe. The software strobe arms a one-cycle pending bit that clears itself. In direct mode, each accepted sample goes straight to the latch and triggers are ignored. In replay mode, triggers walk a cursor over the stored samples without consuming them. When the cursor passes the newest entry it returns to the oldest one and raises a pass-complete event.

The block reports the following status:
- level flags: full, empty, and at-or-below-watermark;
- sticky event flags: overflow, underflow, and pass-complete, each cleared by writing 1;
- the cursor and write pointers.

An interrupt line and a DMA request line are formed from masked combinations of these flags.

The sample input is a valid/ready stream. While the block is enabled, `smp_ready` is high and every sample offered with `smp_valid` is taken in that cycle. A sample offered while the queue is full is taken and discarded, and it raises the overflow flag. While the block is disabled, `smp_ready` is low and nothing is taken.

Top module: `dac_seq_top`

## Requirements
- R1: Reset state: `dac_out`=0, `empty`=1, `full`=0, both pointers 0, all sticky flags 0, `irq`=0.
- R2: Direct mode (`queue_mode`=0): a sample accepted in cycle t appears on `dac_out` after that edge. Triggers there change nothing: no output change, no underflow, pointers unchanged.
- R3: Queued mode (`queue_mode`=1): accepted samples are stored at `wr_ptr`. Each trigger loads the oldest stored sample into `dac_out`, in write order.
- R4: Trigger selection:
  - `trig_src`=0: each cycle with `hw_trig` high is a trigger, and `dac_out` updates after that edge.
  - `trig_src`=1: a cycle with `sw_trig_wr` high sets a pending bit. That bit triggers once in the next cycle and then clears.
  - The unselected source has no effect.
- R5: With a fill count n from 0 to 16: `full` = (n==16), `empty` = (n==0), and `wm` = (n <= `wm_level`). `full` and `empty` are never both 1.
- R6: A sample accepted while full is dropped and sets `ovf`. `ovf` stays 1 until a cycle with `flag_clr[1]`=1.
- R7: A trigger while empty in queued mode leaves `dac_out` unchanged and sets `unf`. `unf` stays 1 until a cycle with `flag_clr[2]`=1.
- R8: Replay mode (`replay`=1, queued mode):
  - A trigger outputs the entry at the cursor and advances the cursor. It frees nothing, so the fill count and `wr_ptr` are unchanged.
  - After the newest entry is output, the cursor returns to the oldest entry and `pass_done` sets.
  - `pass_done` stays 1 until a cycle with `flag_clr[0]`=1.
- R9: Pointers:
  - `rd_ptr` shows the cursor (the oldest entry outside replay mode).
  - `wr_ptr` shows the next write slot.
  - Both count modulo 16.
  - `q_clear` returns both pointers to 0 and makes the queue empty.
- R10: `irq` is the OR of {`unf`,`ovf`,`pass_done`,`wm`,`empty`,`full`} ANDed with `irq_en`, where `irq_en` bit 0 masks full, bit 1 empty, bit 2 wm, bit 3 pass_done, bit 4 ovf, and bit 5 unf. `dma_req` = (`empty` & `dma_en[0]`) | (`wm` & `dma_en[1]`).
- R11: With `en`=0:
  - `smp_ready` is 0.
  - Offered samples and triggers change neither the pointers, `dac_out`, nor the flags.
  - Only `q_clear` and `flag_clr` still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| queue_mode | input | 1 | 1 = queued mode, 0 = direct mode |
| replay | input | 1 | Replay (looping) mode in queued mode |
| trig_src | input | 1 | 0 = hardware trigger, 1 = software trigger |
| hw_trig | input | 1 | Hardware trigger pulse |
| sw_trig_wr | input | 1 | Software trigger strobe |
| q_clear | input | 1 | Empties the queue and zeroes the pointers |
| wm_level | input | 4 | Watermark level |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted when high with valid |
| smp_data | input | 12 | Sample value |
| flag_clr | input | 3 | Write-1 clears: bit0 pass_done, bit1 ovf, bit2 unf |
| irq_en | input | 6 | Interrupt masks |
| dma_en | input | 2 | DMA masks: bit0 empty, bit1 wm |
| dac_out | output | 12 | Output latch |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| wm | output | 1 | Fill count at or below watermark |
| pass_done | output | 1 | Sticky replay-pass complete |
| ovf | output | 1 | Sticky overflow |
| unf | output | 1 | Sticky underflow |
| rd_ptr | output | 4 | Cursor pointer |
| wr_ptr | output | 4 | Write pointer |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
**Fill-level sweep.** The queue is filled to every level from 0 to 16 and drained in write order. At each level the watermark is swept over all 16 settings, and the drain alternates hardware and software triggers. This separates off-by-one errors in the count, in full/empty, and in the watermark comparison. It also exposes a trigger path that drops or duplicates pops.

**Overflow and underflow.** A seventeenth write must be dropped without disturbing the stored order. An extra trigger on an empty queue must leave the output unchanged.

**Replay.** A replay run over three entries checks the cursor wrap and the pass event, and shows that replay consumes nothing.

**Other behaviour.** Direct-mode writes, triggers from the unselected source, and stimulus with the block disabled must all leave the state untouched. The interrupt masks are swept over all 64 values against a known flag set.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  // Status vector; packed so that full sits at bit 0, matching the mask order.
  typedef struct packed {
    logic unf;
    logic ovf;
    logic pass;
    logic wm;
    logic empty;
    logic full;
  } dac_flags_t;

  localparam int unsigned NUM_FLAGS = $bits(dac_flags_t);

  // Write-1-clear bit positions for the sticky events.
  localparam int unsigned CLR_PASS = 0;
  localparam int unsigned CLR_OVF  = 1;
  localparam int unsigned CLR_UNF  = 2;
  localparam int unsigned NUM_CLR  = 3;
endpackage

// File: rtl/dac_seq_trig.sv
module dac_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trig_src,
  input  logic hw_trig,
  input  logic sw_trig_wr,
  output logic trig
);
  logic sw_pend;

  // Pending software trigger lives for exactly one cycle after its strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= 1'b0;
    else        sw_pend <= sw_trig_wr;
  end

  assign trig = en & (trig_src ? sw_pend : hw_trig);
endmodule

// File: rtl/dac_seq_store.sv
module dac_seq_store #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          queue_mode,
  input  logic          replay,
  input  logic          q_clear,
  input  logic          push_v,
  input  logic [DW-1:0] push_d,
  input  logic          trig,
  output logic [DW-1:0] dac_out,
  output logic [AW:0]   count,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          ovf_ev,
  output logic          unf_ev,
  output logic          pass_ev
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   head, wr, cur;
  logic [AW:0]   off_nxt;
  logic [AW:0]   rd_idx;
  logic          act, is_full, is_empty;
  logic          do_push, do_pop, wrap;

  assign count    = wr - head;
  assign is_full  = (count == DEPTH_C);
  assign is_empty = (count == '0);

  assign act     = en & queue_mode;
  assign do_push = act & push_v & ~is_full;
  assign do_pop  = act & trig & ~is_empty;
  assign ovf_ev  = act & push_v & is_full;
  assign unf_ev  = act & trig & is_empty;

  // Replay cursor offset from the oldest entry; wrap once past the newest.
  assign off_nxt = (cur - head) + 1'b1;
  assign wrap    = (off_nxt >= count);
  assign pass_ev = do_pop & replay & wrap;

  assign rd_idx = replay ? cur : head;
  assign rd_ptr = rd_idx[AW-1:0];
  assign wr_ptr = wr[AW-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr[AW-1:0]] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      wr   <= '0;
      cur  <= '0;
    end else if (q_clear) begin
      head <= '0;
      wr   <= '0;
      cur  <= '0;
    end else begin
      if (do_push) wr <= wr + 1'b1;
      if (do_pop && replay) begin
        cur <= wrap ? head : cur + 1'b1;
      end else if (do_pop) begin
        head <= head + 1'b1;
        cur  <= head + 1'b1;
      end else if (!replay) begin
        cur <= head;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_out <= '0;
    end else if (en && !queue_mode && push_v) begin
      dac_out <= push_d;
    end else if (do_pop) begin
      dac_out <= mem[rd_idx[AW-1:0]];
    end
  end
endmodule

// File: rtl/dac_seq_flags.sv
module dac_seq_flags
  import dac_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ovf_ev,
  input  logic                unf_ev,
  input  logic                pass_ev,
  input  logic [NUM_CLR-1:0]  flag_clr,
  input  logic                full,
  input  logic                empty,
  input  logic                wm,
  input  logic [NUM_FLAGS-1:0] irq_en,
  input  logic [1:0]          dma_en,
  output dac_flags_t          flags,
  output logic                irq,
  output logic                dma_req
);
  logic [NUM_CLR-1:0] sticky, events;

  assign events = {unf_ev, ovf_ev, pass_ev};

  // A new event in the same cycle as its clear wins.
  for (genvar g = 0; g < NUM_CLR; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky[g] <= 1'b0;
      else        sticky[g] <= (sticky[g] & ~flag_clr[g]) | events[g];
    end
  end

  always_comb begin
    flags       = '0;
    flags.full  = full;
    flags.empty = empty;
    flags.wm    = wm;
    flags.pass  = sticky[CLR_PASS];
    flags.ovf   = sticky[CLR_OVF];
    flags.unf   = sticky[CLR_UNF];
  end

  assign irq     = |(flags & irq_en);
  assign dma_req = (empty & dma_en[0]) | (wm & dma_en[1]);
endmodule

// File: rtl/dac_seq_top.sv
module dac_seq_top
  import dac_seq_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned SW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 queue_mode,
  input  logic                 replay,
  input  logic                 trig_src,
  input  logic                 hw_trig,
  input  logic                 sw_trig_wr,
  input  logic                 q_clear,
  input  logic [AW-1:0]        wm_level,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [SW-1:0]        smp_data,
  input  logic [NUM_CLR-1:0]   flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_en,
  input  logic [1:0]           dma_en,
  output logic [SW-1:0]        dac_out,
  output logic                 full,
  output logic                 empty,
  output logic                 wm,
  output logic                 pass_done,
  output logic                 ovf,
  output logic                 unf,
  output logic [AW-1:0]        rd_ptr,
  output logic [AW-1:0]        wr_ptr,
  output logic                 irq,
  output logic                 dma_req
);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(1 << AW);

  logic       trig, ovf_ev, unf_ev, pass_ev;
  logic [AW:0] count;
  dac_flags_t flags;

  assign smp_ready = en;
  assign full      = (count == DEPTH_C);
  assign empty     = (count == '0);
  assign wm        = (count <= {1'b0, wm_level});

  dac_seq_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .trig_src   (trig_src),
    .hw_trig    (hw_trig),
    .sw_trig_wr (sw_trig_wr),
    .trig       (trig)
  );

  dac_seq_store #(.AW(AW), .DW(SW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .queue_mode (queue_mode),
    .replay     (replay),
    .q_clear    (q_clear),
    .push_v     (smp_valid),
    .push_d     (smp_data),
    .trig       (trig),
    .dac_out    (dac_out),
    .count      (count),
    .rd_ptr     (rd_ptr),
    .wr_ptr     (wr_ptr),
    .ovf_ev     (ovf_ev),
    .unf_ev     (unf_ev),
    .pass_ev    (pass_ev)
  );

  dac_seq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_ev   (ovf_ev),
    .unf_ev   (unf_ev),
    .pass_ev  (pass_ev),
    .flag_clr (flag_clr),
    .full     (full),
    .empty    (empty),
    .wm       (wm),
    .irq_en   (irq_en),
    .dma_en   (dma_en),
    .flags    (flags),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  assign pass_done = flags.pass;
  assign ovf       = flags.ovf;
  assign unf       = flags.unf;
endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned SW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          queue_mode,
  input logic          replay,
  input logic          q_clear,
  input logic          smp_valid,
  input logic [SW-1:0] smp_data,
  input logic [2:0]    flag_clr,
  input logic [5:0]    irq_en,
  input logic [SW-1:0] dac_out,
  input logic          full,
  input logic          empty,
  input logic          ovf,
  input logic          unf,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] wr_ptr,
  input logic          irq
);
  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && !queue_mode && smp_valid |=> dac_out == $past(smp_data));

  assert_full_empty_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !flag_clr[1] |=> ovf);

  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !flag_clr[2] |=> unf);

  assert_replay_keeps_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    replay && !smp_valid && !q_clear |=> $stable(full) && $stable(empty));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> empty && rd_ptr == '0 && wr_ptr == '0);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == '0 |-> !irq);

  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !q_clear |=> $stable(wr_ptr) && $stable(rd_ptr) && $stable(dac_out));
endmodule

bind dac_seq_top dac_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .queue_mode (queue_mode),
  .replay     (replay),
  .q_clear    (q_clear),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .flag_clr   (flag_clr),
  .irq_en     (irq_en),
  .dac_out    (dac_out),
  .full       (full),
  .empty      (empty),
  .ovf        (ovf),
  .unf        (unf),
  .rd_ptr     (rd_ptr),
  .wr_ptr     (wr_ptr),
  .irq        (irq)
);

// File: tb/tb_dac_seq_top.sv
`timescale 1ns/1ps
module tb_dac_seq_top;
  logic clk = 0;
  logic rst_n = 0;
  logic en = 0, queue_mode = 1, replay = 0, trig_src = 0;
  logic hw_trig = 0, sw_trig_wr = 0, q_clear = 0;
  logic [3:0] wm_level = 0;
  logic smp_valid = 0, smp_ready;
  logic [11:0] smp_data = 0;
  logic [2:0] flag_clr = 0;
  logic [5:0] irq_en = 0;
  logic [1:0] dma_en = 0;
  logic [11:0] dac_out;
  logic full, empty, wm, pass_done, ovf, unf, irq, dma_req;
  logic [3:0] rd_ptr, wr_ptr;

  int total = 0, bad = 0;
  bit done = 0;
  int last;

  always #2 clk = ~clk;

  dac_seq_top dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int val(input int n, input int i);
    return (n * 37 + i * 101 + 5) & 12'hFFF;
  endfunction

  task automatic push(input int v);
    smp_valid = 1; smp_data = 12'(v);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic hw();
    trig_src = 0; hw_trig = 1;
    @(negedge clk);
    hw_trig = 0;
  endtask

  task automatic sw();
    trig_src = 1; sw_trig_wr = 1;
    @(negedge clk);
    sw_trig_wr = 0;
    @(negedge clk);
  endtask

  task automatic qclr();
    q_clear = 1; @(negedge clk); q_clear = 0;
  endtask

  task automatic fclr(input logic [2:0] m);
    flag_clr = m; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dac_out", dac_out, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ptrs", {rd_ptr, wr_ptr}, 0);
    chk("R1 sticky", {pass_done, ovf, unf}, 0);
    chk("R1 irq", irq, 0);
    en = 1;
    last = 0;

    // R3 R4 R5 R7 R9: sweep fill levels
    for (int n = 0; n <= 16; n++) begin
      qclr();
      chk("R9 cleared", empty, 1);
      for (int i = 0; i < n; i++) push(val(n, i));
      chk("R9 wr_ptr", wr_ptr, n % 16);
      chk("R5 full", full, int'(n == 16));
      chk("R5 empty", empty, int'(n == 0));
      for (int lv = 0; lv < 16; lv++) begin
        wm_level = 4'(lv); #1;
        chk("R5 wm", wm, int'(n <= lv));
      end
      for (int i = 0; i < n; i++) begin
        if (i % 2 == 0) hw(); else sw();
        chk(i % 2 == 0 ? "R3 R4 hw pop" : "R3 R4 sw pop", dac_out, val(n, i));
        last = val(n, i);
      end
      chk("R5 drained", empty, 1);
      chk("R9 rd_ptr", rd_ptr, n % 16);
      hw();
      chk("R7 unf set", unf, 1);
      chk("R7 out held", dac_out, last);
      fclr(3'b100);
      chk("R7 unf clear", unf, 0);
    end

    // R6 overflow
    qclr();
    for (int i = 0; i < 17; i++) push(val(40, i));
    chk("R6 ovf", ovf, 1);
    chk("R6 wr_ptr", wr_ptr, 0);
    chk("R6 full", full, 1);
    for (int i = 0; i < 16; i++) begin
      hw();
      chk("R6 order", dac_out, val(40, i));
    end
    chk("R6 sticky", ovf, 1);
    fclr(3'b010);
    chk("R6 clear", ovf, 0);

    // R4 unselected source
    push(12'h123);
    trig_src = 1; hw_trig = 1; @(negedge clk); hw_trig = 0;
    chk("R4 hw ignored", dac_out, val(40, 15));
    trig_src = 0; sw_trig_wr = 1; @(negedge clk); sw_trig_wr = 0; @(negedge clk);
    chk("R4 sw ignored", dac_out, val(40, 15));
    chk("R4 still stored", empty, 0);
    hw();
    chk("R4 hw pop", dac_out, 12'h123);

    // R8 replay
    qclr();
    push(12'hA01); push(12'hB02); push(12'hC03);
    replay = 1;
    for (int k = 0; k < 7; k++) begin
      hw();
      chk("R8 out", dac_out, (k % 3 == 0) ? 12'hA01 : (k % 3 == 1) ? 12'hB02 : 12'hC03);
      chk("R8 cursor", rd_ptr, (k + 1) % 3);
      chk("R8 pass", pass_done, int'(k >= 2));
      chk("R8 kept", {empty, wr_ptr}, 3);
    end
    replay = 0;
    @(negedge clk);
    hw();
    chk("R8 head kept", dac_out, 12'hA01);
    chk("R8 rd_ptr", rd_ptr, 1);
    fclr(3'b001);
    chk("R8 pass clear", pass_done, 0);

    // R2 direct mode
    qclr();
    queue_mode = 0;
    push(12'h5A5);
    chk("R2 direct", dac_out, 12'h5A5);
    chk("R2 not stored", {empty, wr_ptr}, 5'h10);
    hw();
    chk("R2 trig ignored", dac_out, 12'h5A5);
    chk("R2 no unf", unf, 0);
    queue_mode = 1;

    // R11 disabled
    push(12'h777);
    en = 0; #1;
    chk("R11 ready low", smp_ready, 0);
    push(12'h111);
    hw();
    chk("R11 held ptr", wr_ptr, 1);
    chk("R11 held out", dac_out, 12'h5A5);
    chk("R11 no unf", unf, 0);
    en = 1;
    hw();
    chk("R11 resumed", dac_out, 12'h777);

    // R10 masks: empty, wm set (level 0); unf set
    wm_level = 0;
    hw();
    for (int m = 0; m < 64; m++) begin
      irq_en = 6'(m); #1;
      chk("R10 irq", irq, int'((m & 6'b100110) != 0));
    end
    irq_en = 0;
    for (int d = 0; d < 4; d++) begin
      dma_en = 2'(d); #1;
      chk("R10 dma empty", dma_req, int'(d != 0));
    end
    fclr(3'b100);
    for (int i = 0; i < 5; i++) push(i);
    wm_level = 2;
    for (int d = 0; d < 4; d++) begin
      dma_en = 2'(d); #1;
      chk("R10 dma none", dma_req, 0);
    end
    wm_level = 5;
    for (int d = 0; d < 4; d++) begin
      dma_en = 2'(d); #1;
      chk("R10 dma wm", dma_req, d >> 1);
    end
    dma_en = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule